// File: doc/BRIEF.md
# Master Data Buffer

A byte-wide, four-slot holding buffer placed between a host register port and a two-wire bus master engine. The host writes outgoing bytes into it one at a time and reads incoming bytes out of it one at a time; the head byte is always visible on the read port. Two status flags, "has data" and "full", report the fill state to the surrounding register file.

Besides host pushes and pops, the buffer accepts a flush command that empties it at once, and a bulk load from the bus engine that overwrites every slot and sets the fill level after a receive of up to four bytes. A read of the empty buffer yields 0xFF, and a write to the full buffer is dropped without any side effect. The flags are derived from the fill level, never from a separate tally.

Top module: `mstr_data_buf`

## Requirements
- R1: After reset the buffer is empty: `has_data_o` and `full_o` are 0 and `rd_data_o` reads 0xFF.
- R2: A push appends `push_data_i` behind the bytes already held; the first push into an empty buffer sets `has_data_o` in the following cycle.
- R3: A push (without pop, flush or load) while four bytes are held is ignored: `full_o` stays 1 and the held bytes and their order are unchanged.
- R4: `rd_data_o` always shows the oldest held byte; a pop removes it and the remaining bytes move down one place, so bytes leave in the order they entered.
- R5: While empty, `rd_data_o` is 0xFF and a pop (without push or load) changes nothing: the buffer stays empty.
- R6: The push that makes four bytes held sets `full_o`; a pop while full clears `full_o`; the pop of the last held byte clears `has_data_o`. `full_o` is never 1 while `has_data_o` is 0.
- R7: `flush_i` empties the buffer and clears both flags in the next cycle; it wins over push, pop and load in the same cycle, after which reads give 0xFF.
- R8: `load_i` (without flush) sets the fill level to N = `load_cnt_i`, clamped to 4, with held byte k taken from `load_data_i[8k+7:8k]` (byte 0 is the oldest); `has_data_o` = (N ≥ 1), `full_o` = (N = 4). Push and pop in the same cycle are ignored.
- R9: A push and a pop in the same cycle are applied pop first, then push: with four bytes held both take effect and `full_o` stays 1; with the buffer empty the pop is ignored and the push is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Host write of the data port |
| push_data_i | input | 8 | Byte written by the host |
| pop_i | input | 1 | Host read of the data port (consumes the head) |
| rd_data_o | output | 8 | Head byte, or 0xFF when empty |
| flush_i | input | 1 | Empty the buffer |
| load_i | input | 1 | Bulk load from the bus engine after a receive |
| load_cnt_i | input | 3 | Number of bytes received (clamped to 4) |
| load_data_i | input | 32 | Received bytes, byte k in bits 8k+7:8k |
| has_data_o | output | 1 | At least one byte held |
| full_o | output | 1 | Four bytes held |

## Verification
The assertions take each command as a single-cycle request sampled at the rising clock edge, with `load_cnt_i` meaningful only while `load_i` is high, and they qualify every property with the commands of higher priority deasserted. The stimulus changes inputs only on falling edges, holds each request for exactly one cycle and mixes directed corner sequences (overfill, underflow, collisions of push and pop at both extremes, flush and load against other requests, load counts above four) with a pseudo-random stretch of combined requests, all compared against a queue model.

// File: rtl/mdb_pkg.sv
package mdb_pkg;
  typedef enum logic [1:0] {
    OP_HOLD,
    OP_FLUSH,
    OP_LOAD,
    OP_STEP
  } mdb_op_e;
endpackage

// File: rtl/mdb_ctrl.sv
module mdb_ctrl
  import mdb_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             flush_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_cnt_i,
  output mdb_op_e          op_o,
  output logic             pop_o,
  output logic             push_o,
  output logic [CNT_W-1:0] slot_o,
  output logic [CNT_W-1:0] cnt_nxt_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [CNT_W-1:0] cnt_q, after_pop, load_n, cnt_d;
  logic             pop_ok, push_ok;
  mdb_op_e          op;

  always_comb begin
    pop_ok    = pop_i && (cnt_q != '0);
    after_pop = pop_ok ? cnt_q - 1'b1 : cnt_q;
    // pop frees a slot before the push looks for room
    push_ok   = push_i && (after_pop != FULL_CNT);
    load_n    = (load_cnt_i > FULL_CNT) ? FULL_CNT : load_cnt_i;
    if (flush_i) begin
      op    = OP_FLUSH;
      cnt_d = '0;
    end else if (load_i) begin
      op    = OP_LOAD;
      cnt_d = load_n;
    end else if (pop_ok || push_ok) begin
      op    = OP_STEP;
      cnt_d = after_pop + CNT_W'(push_ok);
    end else begin
      op    = OP_HOLD;
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign op_o      = op;
  assign pop_o     = pop_ok && (op == OP_STEP);
  assign push_o    = push_ok && (op == OP_STEP);
  assign slot_o    = after_pop;
  assign cnt_nxt_o = cnt_d;
endmodule

// File: rtl/mdb_store.sv
module mdb_store
  import mdb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  mdb_op_e                 op_i,
  input  logic                    pop_i,
  input  logic                    push_i,
  input  logic [CNT_W-1:0]        slot_i,
  input  logic [DATA_W-1:0]       push_data_i,
  input  logic [DEPTH*DATA_W-1:0] load_data_i,
  output logic [DATA_W-1:0]       head_o
);
  logic [DATA_W-1:0] ent [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    logic [DATA_W-1:0] slot_q, below;

    if (k == DEPTH - 1) begin : g_last
      assign below = '0;
    end else begin : g_inner
      assign below = ent[k+1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_q <= '0;
      end else begin
        case (op_i)
          OP_FLUSH: slot_q <= '0;
          OP_LOAD:  slot_q <= load_data_i[k*DATA_W +: DATA_W];
          OP_STEP: begin
            if (push_i && (slot_i == CNT_W'(k))) slot_q <= push_data_i;
            else if (pop_i)                      slot_q <= below;
          end
          default: ;
        endcase
      end
    end

    assign ent[k] = slot_q;
  end

  assign head_o = ent[0];
endmodule

// File: rtl/mdb_flags.sv
module mdb_flags #(
  parameter int DEPTH = 4,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  output logic             has_data_o,
  output logic             full_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      has_data_o <= 1'b0;
      full_o     <= 1'b0;
    end else begin
      has_data_o <= (cnt_nxt_i != '0);
      full_o     <= (cnt_nxt_i == CNT_W'(DEPTH));
    end
  end
endmodule

// File: rtl/mstr_data_buf.sv
module mstr_data_buf
  import mdb_pkg::*;
#(
  parameter int                 DATA_W    = 8,
  parameter int                 DEPTH     = 4,
  parameter logic [DATA_W-1:0]  EMPTY_VAL = '1,
  localparam int                CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    push_i,
  input  logic [DATA_W-1:0]       push_data_i,
  input  logic                    pop_i,
  output logic [DATA_W-1:0]       rd_data_o,
  input  logic                    flush_i,
  input  logic                    load_i,
  input  logic [CNT_W-1:0]        load_cnt_i,
  input  logic [DEPTH*DATA_W-1:0] load_data_i,
  output logic                    has_data_o,
  output logic                    full_o
);
  mdb_op_e           op;
  logic              pop_go, push_go;
  logic [CNT_W-1:0]  slot, cnt_nxt;
  logic [DATA_W-1:0] head;

  mdb_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push_i),
    .pop_i      (pop_i),
    .flush_i    (flush_i),
    .load_i     (load_i),
    .load_cnt_i (load_cnt_i),
    .op_o       (op),
    .pop_o      (pop_go),
    .push_o     (push_go),
    .slot_o     (slot),
    .cnt_nxt_o  (cnt_nxt)
  );

  mdb_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .op_i        (op),
    .pop_i       (pop_go),
    .push_i      (push_go),
    .slot_i      (slot),
    .push_data_i (push_data_i),
    .load_data_i (load_data_i),
    .head_o      (head)
  );

  mdb_flags #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_nxt_i  (cnt_nxt),
    .has_data_o (has_data_o),
    .full_o     (full_o)
  );

  assign rd_data_o = has_data_o ? head : EMPTY_VAL;
endmodule

// File: rtl/mdb_checker.sv
module mdb_checker #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              push_i,
  input logic              pop_i,
  input logic              flush_i,
  input logic              load_i,
  input logic [CNT_W-1:0]  load_cnt_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              has_data_o,
  input logic              full_o
);
  // R5: empty buffer reads the fill value
  p_empty_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !has_data_o |-> rd_data_o == '1);

  // R6
  p_full_has_data_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> has_data_o);

  // R5: pop of empty buffer changes nothing
  p_empty_pop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !has_data_o && pop_i && !push_i && !flush_i && !load_i |=> !has_data_o);

  // R2
  p_first_push_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !has_data_o && push_i && !flush_i && !load_i |=> has_data_o);

  // R3
  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i && !pop_i && !flush_i && !load_i |=> full_o && $stable(rd_data_o));

  // R6: pop while full clears full
  p_pop_clears_full_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && pop_i && !push_i && !flush_i && !load_i |=> !full_o && has_data_o);

  // R7
  p_flush_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !has_data_o && !full_o);

  // R8
  p_load_full_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !flush_i && (load_cnt_i >= CNT_W'(DEPTH)) |=> full_o);

  p_load_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !flush_i && (load_cnt_i == '0) |=> !has_data_o);

  // R9
  p_pushpop_full_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i && pop_i && !flush_i && !load_i |=> full_o);
endmodule

bind mstr_data_buf mdb_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/mstr_data_buf_test.sv
module mstr_data_buf_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push = 1'b0, pop = 1'b0, flush = 1'b0, load = 1'b0;
  logic [7:0]  pdata = '0;
  logic [2:0]  lcnt = '0;
  logic [31:0] ldata = '0;
  logic [7:0]  rd;
  logic        has, full;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;
  logic [7:0] sb[$];  // scoreboard of held bytes, oldest first

  always #4 clk = ~clk;

  mstr_data_buf uut (
    .clk_i(clk), .rst_ni(rst_n),
    .push_i(push), .push_data_i(pdata), .pop_i(pop), .rd_data_o(rd),
    .flush_i(flush), .load_i(load), .load_cnt_i(lcnt), .load_data_i(ldata),
    .has_data_o(has), .full_o(full)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_head();
    return (sb.size() == 0) ? 8'hFF : sb[0];
  endfunction

  // monitor: compares the port state with the scoreboard
  task automatic monitor(string req);
    chk(req, "head", rd, exp_head());
    chk(req, "has_data", has, sb.size() != 0);
    chk(req, "full", full, sb.size() == 4);
  endtask

  // driver: one cycle of requests; updates scoreboard pop-first
  task automatic step(string req, bit pu, logic [7:0] pd, bit po,
                      bit fl = 0, bit ld = 0, logic [2:0] lc = 0, logic [31:0] lcd = 0);
    int n;
    @(negedge clk);
    push = pu; pdata = pd; pop = po; flush = fl; load = ld; lcnt = lc; ldata = lcd;
    #1;
    if (po && !fl && !ld) chk(req, "popped byte", rd, exp_head());
    if (fl) sb.delete();
    else if (ld) begin
      sb.delete();
      n = (lc > 4) ? 4 : int'(lc);
      for (int k = 0; k < n; k++) sb.push_back(lcd[8*k +: 8]);
    end else begin
      if (po && sb.size() > 0) void'(sb.pop_front());
      if (pu && sb.size() < 4) sb.push_back(pd);
    end
    @(posedge clk);
    #1;
    push = 0; pop = 0; flush = 0; load = 0;
    monitor(req);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(posedge clk);
    #1;
    monitor("R1");
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    monitor("R1");

    step("R5", 0, 8'h00, 1);            // pop of empty
    step("R2", 1, 8'hA1, 0);            // first push
    step("R2", 1, 8'hB2, 0);
    step("R2", 1, 8'hC3, 0);
    step("R6", 1, 8'hD4, 0);            // fourth push: full
    step("R3", 1, 8'hEE, 0);            // dropped
    step("R3", 1, 8'h11, 0);            // dropped
    step("R6", 0, 8'h00, 1);            // pop while full
    step("R4", 0, 8'h00, 1);
    step("R4", 0, 8'h00, 1);
    step("R6", 0, 8'h00, 1);            // last byte
    step("R5", 0, 8'h00, 1);

    step("R9", 1, 8'h21, 1);            // both on empty
    step("R9", 1, 8'h22, 1);            // both with one held
    step("R2", 1, 8'h23, 0);
    step("R2", 1, 8'h24, 0);
    step("R6", 1, 8'h25, 0);
    step("R9", 1, 8'h26, 1);            // both while full
    step("R9", 1, 8'h27, 1);
    step("R4", 0, 8'h00, 1);

    step("R7", 1, 8'h31, 1, 1, 1, 3'd2, 32'h01020304);  // flush wins
    step("R7", 0, 8'h00, 1);
    step("R8", 1, 8'h41, 1, 0, 1, 3'd3, 32'hDDCCBBAA);  // load 3
    step("R8", 0, 8'h00, 1);
    step("R8", 1, 8'h42, 0);
    step("R8", 0, 8'h00, 0, 0, 1, 3'd4, 32'h44332211);  // load 4
    step("R3", 1, 8'h99, 0);
    step("R8", 0, 8'h00, 1);
    step("R8", 0, 8'h00, 0, 0, 1, 3'd7, 32'h88776655);  // clamped
    step("R8", 0, 8'h00, 1);
    step("R8", 1, 8'h55, 0, 0, 1, 3'd0, 32'h12345678);  // load 0
    step("R5", 0, 8'h00, 1);

    lf = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step("R4", lf[0], lf[15:8], lf[1], lf[7:2] == 0, lf[6:3] == 1, lf[10:8], {lf, ~lf});
    end

    @(negedge clk) rst_n = 1'b0;
    sb.delete();
    #1;
    monitor("R1");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule